// File: doc/BRIEF.md
# External Bus Chip-Select and Wait-State Controller

This block sits between a bus master and an external memory bus. When the master requests an access, the block compares the address against four fixed windows and drives one of four active-low chip selects. The four windows are 16 KB, 1 MB, 2 MB and 4 MB. The select stays low until the access is terminated. The block then pulses a ready signal back to the master for one cycle.

Each select has its own two-bit termination mode. The mode picks one of two shared wait-state generators, A or B, or a handshake on an external wait input. Each generator is loaded with its programmed count when the access starts. In handshake mode, the slow device holds the wait input low to stretch the access. That input passes through a synchronizer, and the access ends once the synchronized wait is seen high. A handshake that never releases is cut off by a timeout and flagged as an error.

Top module: `xbus_cs_wait`

## Requirements
- R1: With the default parameters, addresses 0x700000 to 0x703FFF drive cs_n[0] low, 0x600000 to 0x6FFFFF drive cs_n[1] low, 0x400000 to 0x5FFFFF drive cs_n[2] low, and 0x000000 to 0x3FFFFF drive cs_n[3] low. The select goes low in the first cycle after the clock edge that accepts req.
- R2: At most one select is low at any time, and the lowest-numbered matching select wins. An accepted address outside every window drives no select. In that case ready pulses in the first cycle after acceptance, with bus_err low.
- R3: Select i takes its mode from term_mode[2i+1:2i]. Mode 00 uses generator A, loaded from ws_a. The select is low for ws_a+1 cycles, and ready is high in the last of them.
- R4: Mode 01 uses generator B, loaded from ws_b, with the same timing: the select is low for ws_b+1 cycles. The count of the unused generator has no effect.
- R5: The count and the mode are captured when the access is accepted. Changing ws_a, ws_b or term_mode during an access does not change its length.
- R6: Modes 10 and 11 end the access on the synchronized deassertion (high level) of ext_wait_n. This uses a two-flop synchronizer and a minimum of three cycles. If ext_wait_n is high from acceptance on, ready comes in cycle 3 after acceptance. If ext_wait_n goes high during cycle k, where k is 1 or more, ready comes in cycle max(3, k+2).
- R7: If the handshake has not ended by cycle 256 after acceptance, ready and bus_err are both high in cycle 256. bus_err is never high without ready.
- R8: Ready is high for exactly one cycle per access. The select returns high in the cycle after ready.
- R9: A req raised while an access is in progress is ignored. The active select and the access length are unchanged, and no second access follows.
- R10: After reset, all selects are high and ready and bus_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, accepted only while idle |
| addr | input | ADDR_W (23) | Access address |
| term_mode | input | 2*NUM_CS (8) | Per-select termination mode, two bits per select |
| ws_a | input | WS_W (4) | Extra-cycle count for wait-state generator A |
| ws_b | input | WS_W (4) | Extra-cycle count for wait-state generator B |
| ext_wait_n | input | 1 | Asynchronous wait from the device, low stretches the access |
| cs_n | output | NUM_CS (4) | Active-low chip selects |
| ready | output | 1 | One-cycle completion pulse to the master |
| bus_err | output | 1 | Handshake timeout, high together with ready |

## Verification
Several rules are checked by properties on every cycle. Selects stay one-hot-or-none. Ready lasts a single cycle. The select is released after completion and holds steady through an access, whatever req does. An error never comes without ready, and no select stays low beyond the timeout bound.

Other behaviour is shown only by the bench's sweeps. These cover the window boundaries and the access lengths for every count, generator and select. They also cover the handshake latency for chosen release times, including the cases one cycle either side of the timeout, and the capture of the configuration at acceptance.

// File: rtl/xbus_cs_pkg.sv
package xbus_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_EXT   = 2'd2
  } seq_state_t;

  // Mode field: bit 1 set selects the external handshake, else bit 0 picks the generator.
  function automatic logic mode_is_ext(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic mode_gen_idx(input logic [1:0] mode);
    return mode[0];
  endfunction

  // Lowest-numbered set bit survives; all others cleared.
  function automatic logic [3:0] keep_lowest4(input logic [3:0] v);
    return v & (~v + 4'd1);
  endfunction

endpackage

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode #(
  parameter int ADDR_W = 23,
  parameter int NUM_CS = 4,
  parameter logic [ADDR_W-1:0] CS_BASE [NUM_CS] = '{default: '0},
  parameter int WIN_LG [NUM_CS] = '{default: 14}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CS-1:0] hit_onehot
);

  logic [NUM_CS-1:0] raw_hit;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    localparam int LG = WIN_LG[i];
    localparam logic [ADDR_W-1:0] BASE = CS_BASE[i];
    // Window matches when all address bits above its size agree with the base.
    assign raw_hit[i] = (addr[ADDR_W-1:LG] == BASE[ADDR_W-1:LG]);
  end

  // Priority to the lowest index: isolate the lowest set bit.
  assign hit_onehot = raw_hit & (~raw_hit + NUM_CS'(1));

endmodule

// File: rtl/xbus_ws_gen.sv
module xbus_ws_gen #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  input  logic            run,
  output logic            expired
);

  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - WS_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/xbus_cs_wait.sv
module xbus_cs_wait
  import xbus_cs_pkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter int NUM_CS      = 4,
  parameter int WS_W        = 4,
  parameter int TMO_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CS_BASE [NUM_CS] =
    '{ADDR_W'(32'h700000), ADDR_W'(32'h600000), ADDR_W'(32'h400000), ADDR_W'(32'h000000)},
  parameter int WIN_LG [NUM_CS] = '{14, 20, 21, 22}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*NUM_CS-1:0]   term_mode,
  input  logic [WS_W-1:0]       ws_a,
  input  logic [WS_W-1:0]       ws_b,
  input  logic                  ext_wait_n,
  output logic [NUM_CS-1:0]     cs_n,
  output logic                  ready,
  output logic                  bus_err
);

  localparam int NUM_GEN = 2;
  localparam logic [TMO_W-1:0] TMO_LAST = '1;
  localparam logic [TMO_W-1:0] MIN_EXT  = TMO_W'(SYNC_STAGES);

  seq_state_t state_q;
  logic [NUM_CS-1:0] cs_q;
  logic              gen_sel_q;
  logic [TMO_W-1:0]  elapsed_q;
  logic              miss_q;

  logic [NUM_CS-1:0] hit;
  logic              any_hit;
  logic [1:0]        hit_mode;
  logic              start_evt;
  logic              finish_evt;
  logic              cnt_done;
  logic              ext_done;
  logic              ext_tmo;
  logic              wait_s;
  logic [NUM_GEN-1:0] gen_load;
  logic [NUM_GEN-1:0] gen_run;
  logic [NUM_GEN-1:0] gen_exp;
  logic [WS_W-1:0]    gen_val [NUM_GEN];

  xbus_cs_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CS (NUM_CS),
    .CS_BASE(CS_BASE),
    .WIN_LG (WIN_LG)
  ) u_decode (
    .addr      (addr),
    .hit_onehot(hit)
  );

  assign any_hit = |hit;

  always_comb begin
    hit_mode = 2'b00;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit[i]) hit_mode = term_mode[2*i +: 2];
    end
  end

  assign start_evt = req && (state_q == ST_IDLE);

  assign gen_val[0] = ws_a;
  assign gen_val[1] = ws_b;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    assign gen_load[g] = start_evt && any_hit && !mode_is_ext(hit_mode)
                         && (mode_gen_idx(hit_mode) == 1'(g));
    assign gen_run[g]  = (state_q == ST_COUNT) && (gen_sel_q == 1'(g));
    xbus_ws_gen #(.WS_W(WS_W)) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gen_load[g]),
      .load_val(gen_val[g]),
      .run     (gen_run[g]),
      .expired (gen_exp[g])
    );
  end

  xbus_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ext_wait_n),
    .sync_out(wait_s)
  );

  assign cnt_done   = (state_q == ST_COUNT) && gen_exp[gen_sel_q];
  assign ext_done   = (state_q == ST_EXT) && (elapsed_q >= MIN_EXT) && wait_s;
  assign ext_tmo    = (state_q == ST_EXT) && !ext_done && (elapsed_q == TMO_LAST);
  assign finish_evt = cnt_done || ext_done || ext_tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cs_q      <= '0;
      gen_sel_q <= 1'b0;
      elapsed_q <= '0;
      miss_q    <= 1'b0;
    end else begin
      miss_q <= start_evt && !any_hit;
      case (state_q)
        ST_IDLE: begin
          elapsed_q <= '0;
          if (start_evt && any_hit) begin
            cs_q      <= hit;
            gen_sel_q <= mode_gen_idx(hit_mode);
            state_q   <= mode_is_ext(hit_mode) ? ST_EXT : ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (finish_evt) begin
            cs_q    <= '0;
            state_q <= ST_IDLE;
          end
        end
        ST_EXT: begin
          if (finish_evt) begin
            cs_q      <= '0;
            elapsed_q <= '0;
            state_q   <= ST_IDLE;
          end else begin
            elapsed_q <= elapsed_q + TMO_W'(1);
          end
        end
        default: begin
          cs_q    <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign cs_n    = ~cs_q;
  assign ready   = finish_evt || miss_q;
  assign bus_err = ext_tmo;

endmodule

// File: rtl/xbus_cs_wait_chk.sv
module xbus_cs_wait_chk #(
  parameter int NUM_CS = 4,
  parameter int TMO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              ready,
  input logic              bus_err,
  input logic              start_evt,
  input logic              finish_evt
);

  localparam int LOW_W = TMO_W + 2;
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(2**TMO_W);

  logic [LOW_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (cs_n != '1) low_cnt <= low_cnt + LOW_W'(1);
    else low_cnt <= '0;
  end

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_start_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cs_n != '1) || ready);

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (cs_n == '1));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && !finish_evt) |=> $stable(cs_n));

  assert_err_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ready);

  assert_low_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LOW_MAX);

endmodule

bind xbus_cs_wait xbus_cs_wait_chk #(
  .NUM_CS(NUM_CS),
  .TMO_W (TMO_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .ready     (ready),
  .bus_err   (bus_err),
  .start_evt (start_evt),
  .finish_evt(finish_evt)
);

// File: tb/xbus_cs_wait_tb.sv
module xbus_cs_wait_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [22:0] addr = '0;
  logic [7:0]  term_mode = '0;
  logic [3:0]  ws_a = '0;
  logic [3:0]  ws_b = '0;
  logic        ext_wait_n = 1'b1;
  logic [3:0]  cs_n;
  logic        ready;
  logic        bus_err;

  int checks = 0;
  int fails  = 0;

  int base_tab [4] = '{32'h700000, 32'h600000, 32'h400000, 32'h000000};
  int lg_tab   [4] = '{14, 20, 21, 22};

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_cs_wait u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .addr      (addr),
    .term_mode (term_mode),
    .ws_a      (ws_a),
    .ws_b      (ws_b),
    .ext_wait_n(ext_wait_n),
    .cs_n      (cs_n),
    .ready     (ready),
    .bus_err   (bus_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One access. raise_at < 0: counter mode, wait input untouched.
  // raise_at == 0: wait already high; k > 0: raised during cycle k after acceptance.
  // disturb: in cycle 1 change the config, in cycle 2 pulse req at a select-1 address.
  task automatic do_access(input logic [22:0] a, input logic [3:0] exp_cs,
                           input int exp_lat, input bit exp_err, input int raise_at,
                           input bit disturb, input string tag);
    int n = 0;
    bit seen = 0;
    bit cs_ok = 1;
    @(negedge clk);
    addr = a;
    req  = 1'b1;
    if (raise_at >= 0) ext_wait_n = (raise_at == 0);
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= 400; k++) begin
      n = k;
      if (cs_n !== exp_cs) cs_ok = 0;
      if (ready === 1'b1) begin
        seen = 1;
        break;
      end
      if (raise_at > 0 && k == raise_at) ext_wait_n = 1'b1;
      if (disturb && k == 1) begin
        ws_a = 4'd0;
        ws_b = 4'd0;
        term_mode = 8'hAA;
      end
      if (disturb && k == 2) begin
        req  = 1'b1;
        addr = 23'h600010;
      end
      if (disturb && k == 3) req = 1'b0;
      @(negedge clk);
    end
    check(seen, {tag, " ready seen"}, seen, 1);
    check(n == exp_lat, {tag, " latency"}, n, exp_lat);
    check(cs_ok, {tag, " select during access"}, int'(cs_n), int'(exp_cs));
    check(bus_err === exp_err, {tag, " bus_err"}, int'(bus_err), int'(exp_err));
    @(negedge clk);
    check(cs_n === 4'hF && ready === 1'b0, {tag, " R8 release"}, int'({ready, cs_n}), 15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(cs_n === 4'hF, "R10 cs_n after reset", int'(cs_n), 15);
    check(ready === 1'b0 && bus_err === 1'b0, "R10 ready/err after reset",
          int'({ready, bus_err}), 0);

    // R3 / R4: every select, both generators, every count; other generator holds 15-n
    for (int i = 0; i < 4; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int n = 0; n < 16; n++) begin
          int off = (n * 4099 + i * 77) % (1 << lg_tab[i]);
          term_mode = {4{1'b0, 1'(m)}};
          ws_a = (m == 0) ? 4'(n) : 4'(15 - n);
          ws_b = (m == 1) ? 4'(n) : 4'(15 - n);
          do_access(23'(base_tab[i] + off), ~(4'b1 << i), n + 1, 1'b0, -1, 1'b0,
                    (m == 0) ? "R3 gen A sweep" : "R4 gen B sweep");
        end
      end
    end

    // R1 / R2: window edges and unmapped addresses, generator A with 2 extra cycles
    term_mode = 8'h00;
    ws_a = 4'd2;
    do_access(23'h703FFF, 4'b1110, 3, 1'b0, -1, 1'b0, "R1 cs0 top");
    do_access(23'h700000, 4'b1110, 3, 1'b0, -1, 1'b0, "R1 cs0 base");
    do_access(23'h6FFFFF, 4'b1101, 3, 1'b0, -1, 1'b0, "R1 cs1 top");
    do_access(23'h5FFFFF, 4'b1011, 3, 1'b0, -1, 1'b0, "R1 cs2 top");
    do_access(23'h3FFFFF, 4'b0111, 3, 1'b0, -1, 1'b0, "R1 cs3 top");
    do_access(23'h000000, 4'b0111, 3, 1'b0, -1, 1'b0, "R1 cs3 base");
    do_access(23'h704000, 4'b1111, 1, 1'b0, -1, 1'b0, "R2 unmapped above cs0");
    do_access(23'h7FFFFF, 4'b1111, 1, 1'b0, -1, 1'b0, "R2 unmapped top");

    // R6 / R7: handshake release times, including both sides of the timeout
    begin
      int rel [10] = '{0, 1, 2, 3, 7, 100, 253, 254, 255, 999};
      for (int j = 0; j < 10; j++) begin
        int r = rel[j];
        int lat = (r >= 255) ? 256 : ((r + 2 > 3) ? r + 2 : 3);
        term_mode = (j % 2 == 0) ? 8'hAA : 8'hFF;
        ext_wait_n = 1'b0;
        repeat (3) @(negedge clk);
        do_access(23'(base_tab[j % 4] + 16), ~(4'b1 << (j % 4)), lat, r >= 255, r, 1'b0,
                  (r >= 255) ? "R7 handshake timeout" : "R6 handshake release");
      end
    end

    // R5 / R9: config changed and req raised mid-access; length fixed at acceptance
    term_mode = 8'h00;
    ws_a = 4'd6;
    do_access(23'h400100, 4'b1011, 7, 1'b0, -1, 1'b1, "R5 R9 mid-access change gen A");
    @(negedge clk);
    check(cs_n === 4'hF && ready === 1'b0, "R9 no queued access", int'({ready, cs_n}), 15);
    term_mode = 8'h55;
    ws_b = 4'd9;
    do_access(23'h000200, 4'b0111, 10, 1'b0, -1, 1'b1, "R5 R9 mid-access change gen B");
    @(negedge clk);
    check(cs_n === 4'hF && ready === 1'b0, "R9 no queued access B", int'({ready, cs_n}), 15);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule